// File: doc/BRIEF.md
# Selectable Rate Sample Strobe Generator

The block turns one master clock into a train of sample strobes at one of three rates. Each strobe is one master cycle wide. A front end that recovers serial data uses the strobe. It needs sixteen samples per data bit. With a 32 MHz master clock the three rates are 16, 8 and 4 MHz, and these serve data rates of 1 Mbps, 500 kbps and 250 kbps. All consumers stay on the master clock and treat the strobe as a clock enable, so the design creates no derived clock.

A free-running 3-bit counter produces the three cadences. A 2-bit rate code picks one cadence. The code is captured only when the counter wraps, so a rate change can never yield a shortened or doubled strobe interval. A registered square wave at the selected rate, with 50% duty, is brought out for observation.

Top module: `rate_strobe_gen`

## Requirements
- R1: With rate code 00 the strobe is high once every 2 master cycles (16 MHz from 32 MHz).
- R2: With rate code 01 the strobe is high once every 4 master cycles (8 MHz).
- R3: With rate code 10 the strobe is high once every 8 master cycles (4 MHz).
- R4: Rate code 11 is not a valid rate. It falls back to the slowest cadence, one strobe every 8 cycles, and never leaves the strobe idle.
- R5: The strobe is never high on two consecutive master cycles.
- R6: A new rate code takes effect only at a counter wrap. Every strobe interval around a change equals either the old period or the new period. Once the new period has appeared, the old period does not return.
- R7: A synchronous active-high reset clears the counter. During reset the strobe and the square wave are low from the first clock edge onward. After release, the first strobe appears on the 8th rising edge, whatever the rate code.
- R8: The square-wave output is registered and has 50% duty at the selected period: it is high for half of any whole number of periods. It is high in every cycle in which the strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 2 | Rate code: 00 /2, 01 /4, 10 /8, 11 falls back to /8 |
| sample_en | output | 1 | One-cycle sample strobe at the selected rate |
| sample_sq | output | 1 | 50% duty square wave at the selected rate |

## Verification
Each of the four rate codes is held steady while the bench measures strobe intervals, pulse counts and square-wave duty. This separates the three cadences from each other and shows that the invalid code lands on the slow cadence and not on silence. Rate codes are also switched at different counter phases, slow to fast and fast to slow. These runs expose any interval that belongs to neither rate, which is the runt or stretched strobe that a careless mux produces. Reset is applied both from power-up and in mid-run, and the bench measures how many edges pass before the first strobe.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
    localparam int CNT_W = 3;
    localparam int IDX_W = (CNT_W > 1) ? $clog2(CNT_W) : 1;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [1:0] {
        RATE_DIV2  = 2'b00,
        RATE_DIV4  = 2'b01,
        RATE_DIV8  = 2'b10,
        RATE_NONE  = 2'b11
    } rate_code_e;

    // Invalid codes fall back to the slowest cadence.
    localparam idx_t IDX_DEFAULT = idx_t'(CNT_W - 1);

    function automatic idx_t code_to_idx(input logic [1:0] code);
        if (code == RATE_NONE || int'(code) >= CNT_W)
            return IDX_DEFAULT;
        return idx_t'(code);
    endfunction

    // Low-bit mask whose all-ones pattern marks one strobe per period.
    function automatic cnt_t idx_mask(input idx_t idx);
        cnt_t m;
        for (int i = 0; i < CNT_W; i++)
            m[i] = (i <= int'(idx));
        return m;
    endfunction
endpackage

// File: rtl/rsg_count.sv
module rsg_count
    import rsg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output cnt_t cnt_o,
    output logic wrap_o
);
    typedef struct packed {
        cnt_t cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + cnt_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cnt_o  = s_q.cnt;
    assign wrap_o = &s_q.cnt;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (s_q.cnt != '1) |=> (s_q.cnt == $past(s_q.cnt) + cnt_t'(1))) else $error("counter step"); // R1
endmodule

// File: rtl/rsg_rate_latch.sv
module rsg_rate_latch
    import rsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] code_i,
    input  logic       wrap_i,
    output idx_t       idx_o
);
    typedef struct packed {
        idx_t idx;
    } sel_state_t;

    sel_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wrap_i)
            s_d.idx = code_to_idx(code_i);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q.idx <= IDX_DEFAULT;
        else     s_q     <= s_d;
    end

    assign idx_o = s_q.idx;

    AST_SEL_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        !wrap_i |=> $stable(s_q.idx)) else $error("rate changed off wrap"); // R6
endmodule

// File: rtl/rsg_strobe.sv
module rsg_strobe
    import rsg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t cnt_i,
    input  idx_t idx_i,
    output logic en_o,
    output logic sq_o
);
    typedef struct packed {
        logic en;
        logic sq;
    } out_state_t;

    out_state_t s_d, s_q;
    cnt_t       mask;

    always_comb begin
        mask   = idx_mask(idx_i);
        s_d    = s_q;
        s_d.en = ((cnt_i & mask) == mask);
        s_d.sq = cnt_i[idx_i];
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign en_o = s_q.en;
    assign sq_o = s_q.sq;

    AST_EN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        s_q.en |=> !s_q.en) else $error("double strobe"); // R5
    AST_EN_IN_SQ: assert property (@(posedge clk) disable iff (rst)
        s_q.en |-> s_q.sq) else $error("strobe outside square high"); // R8
    AST_WRAP_STROBE: assert property (@(posedge clk) disable iff (rst)
        (cnt_i == '1) |=> s_q.en) else $error("no strobe at wrap"); // R6
endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen
    import rsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate_sel,
    output logic       sample_en,
    output logic       sample_sq
);
    cnt_t cnt;
    logic wrap;
    idx_t idx;

    rsg_count u_count (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    rsg_rate_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .code_i (rate_sel),
        .wrap_i (wrap),
        .idx_o  (idx)
    );

    rsg_strobe u_strobe (
        .clk   (clk),
        .rst   (rst),
        .cnt_i (cnt),
        .idx_i (idx),
        .en_o  (sample_en),
        .sq_o  (sample_sq)
    );
endmodule

// File: tb/rate_strobe_gen_bench.sv
module rate_strobe_gen_bench;
    localparam int CLK_HALF = 4;  // 125 MHz
    localparam int WIN      = 24;
    localparam int NV       = 6;
    // {rate code, expected period}
    localparam logic [5:0] VEC [NV] = '{
        {2'b00, 4'd2}, {2'b01, 4'd4}, {2'b10, 4'd8},
        {2'b11, 4'd8}, {2'b01, 4'd4}, {2'b00, 4'd2}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rate_sel = 2'b00;
    logic       sample_en, sample_sq;
    int checks = 0;
    int failures = 0;

    always #CLK_HALF clk = ~clk;

    rate_strobe_gen u_rate_strobe_gen (
        .clk       (clk),
        .rst       (rst),
        .rate_sel  (rate_sel),
        .sample_en (sample_en),
        .sample_sq (sample_sq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] s);
        case (s)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic measure(input int period, input string tag);
        int  last = -1;
        int  bad_val = 0;
        int  pulses = 0;
        int  sq_ones = 0;
        bit  bad = 0;
        bit  dbl = 0;
        bit  prev = 0;
        for (int c = 0; c < WIN; c++) begin
            @(posedge clk); @(negedge clk);
            if (sample_sq) sq_ones++;
            if (sample_en) begin
                if (prev) dbl = 1;
                if (last >= 0 && c - last != period) begin
                    bad = 1; bad_val = c - last;
                end
                last = c;
                pulses++;
            end
            prev = sample_en;
        end
        check(!bad, {tag, " interval"}, bad ? bad_val : period, period);
        check(pulses == WIN / period, {tag, " pulse count"}, pulses, WIN / period);
        check(!dbl, "R5 consecutive strobe", int'(dbl), 0);
        check(sq_ones == WIN / 2, "R8 square duty", sq_ones, WIN / 2);
    endtask

    task automatic change_test(input logic [1:0] from_s, input int from_p,
                               input logic [1:0] to_s, input int to_p, input int skew);
        int last = -1;
        int bad_val = 0;
        bit bad = 0;
        bit seen_new = 0;
        rate_sel = from_s;
        repeat (16 + skew) @(negedge clk);
        rate_sel = to_s;
        for (int c = 0; c < 48; c++) begin
            @(posedge clk); @(negedge clk);
            if (sample_en) begin
                if (last >= 0) begin
                    if (c - last != from_p && c - last != to_p) begin bad = 1; bad_val = c - last; end
                    if (seen_new && c - last == from_p) begin bad = 1; bad_val = c - last; end
                    if (c - last == to_p) seen_new = 1;
                end
                last = c;
            end
        end
        check(!bad, "R6 interval across change", bad ? bad_val : to_p, to_p);
        check(seen_new, "R6 new rate reached", int'(seen_new), 1);
    endtask

    initial begin
        #(CLK_HALF * 2 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog requirement=all actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int first;
        // R7: quiet outputs while reset is held
        repeat (3) @(negedge clk);
        check(!sample_en && !sample_sq, "R7 reset outputs", {sample_en, sample_sq}, 0);

        // R7: first strobe on the 8th edge after release
        rate_sel = 2'b00;
        rst = 1'b0;
        first = -1;
        for (int k = 1; k <= 12; k++) begin
            @(posedge clk); @(negedge clk);
            if (sample_en && first < 0) first = k;
        end
        check(first == 8, "R7 first strobe edge", first, 8);

        // Steady rates from the vector table (R1..R4, R5, R8)
        for (int v = 0; v < NV; v++) begin
            rate_sel = VEC[v][5:4];
            repeat (12) @(negedge clk);
            measure(int'(VEC[v][3:0]), tag_of(VEC[v][5:4]));
        end

        // R6: rate changes at different counter phases
        change_test(2'b00, 2, 2'b10, 8, 0);
        change_test(2'b10, 8, 2'b00, 2, 3);
        change_test(2'b01, 4, 2'b00, 2, 5);

        // R7: reset in mid-run forces outputs low at the next edge
        rate_sel = 2'b00;
        repeat (15) @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check(!sample_en && !sample_sq, "R7 mid-run reset", {sample_en, sample_sq}, 0);
        @(posedge clk); @(negedge clk);
        check(!sample_en, "R7 reset held", int'(sample_en), 0);
        rst = 1'b0;
        first = -1;
        for (int k = 1; k <= 12; k++) begin
            @(posedge clk); @(negedge clk);
            if (sample_en && first < 0) first = k;
        end
        check(first == 8, "R7 first strobe after mid-run reset", first, 8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule